// File: doc/BRIEF.md
# Ring-Oscillator Phase-Transition Quantizer

This block is the digital back end of an oscillator-based quantizer. A multi-phase ring oscillator whose frequency follows an analog input presents one tap per delay stage. On every reference clock edge the block stores the tap word. It compares that word stage by stage with the word stored one period earlier. The number of stages that changed state is the output code. That code is the first-order difference of the sampled oscillator phase, so it tracks the mean oscillator frequency over one reference period.

The per-stage toggle vector is also brought out unchanged. It can switch one unit feedback DAC element per stage. Because oscillator edges travel around the ring, the set of enabled elements rotates from period to period without any sorting logic. This spreads element mismatch in the same way a barrel-shift element selector does. The stage count is a parameter; 31 stages is the default. Two summing structures are available for the ones count: a serial chain or grouped partial sums.

Top module: `ring_phase_quantizer`

## Requirements
- R1: Each rising reference edge (with reset low) stores `phase_taps` as the newest sample, and the sample that was newest moves to the previous-sample slot.
- R2: `dac_enable` bit i equals bit i of the newer sample XOR bit i of the older sample, for every stage i.
- R3: `out_count` equals the number of ones in `dac_enable`. It is `$clog2(N_STAGES+1)` bits wide, so the all-toggled value N_STAGES is representable (31 with the default).
- R4: `out_count` and `dac_enable` are registered together. They appear one reference cycle after the edge that stored the newer of their two samples: samples stored at edges k-2 and k-1 are visible after edge k.
- R5: A synchronous active-high `rst` clears both sample slots, `out_count`, `dac_enable` and `out_valid` at the next rising edge.
- R6: `out_valid` stays low until two samples have been stored after reset. It rises after the third edge following reset and then stays high until the next reset. `out_count` and `dac_enable` hold zero while it is low.
- R7: When the taps follow an ideal ring that advances by s stages per period (0 <= s <= N_STAGES), `out_count` equals s. This includes advances that wrap past stage N_STAGES-1 back to stage 0.
- R8: With 9 stages, the sample sequence 101010101, 010110101, 110101010, 101010010 (stage 8 leftmost) gives vectors 111100000, 100011111, 011111000 and counts 4, 6, 5.
- R9: When the taps do not change between two samples, `out_count` is 0 and `dac_enable` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_taps | input | N_STAGES | Ring oscillator stage outputs, bit i is stage i |
| out_valid | output | 1 | High once the output is derived from two real samples |
| out_count | output | $clog2(N_STAGES+1) | Number of stages that toggled in one period |
| dac_enable | output | N_STAGES | Per-stage toggle vector, one enable per unit DAC element |

## Verification
The checker assumes that no stage toggles more than once per reference period. Under that assumption the count really is the phase advance, and a count above N_STAGES can only come from a fault. It also assumes that the taps are stable around the sampling edge. The bench generates the taps from an ideal ring model. That model moves a thermometer front around a 2·N_STAGES phase circle by at most N_STAGES positions per period, and it changes the taps only at the falling edge. The stated 9-stage sequence is driven onto a second instance with arbitrary words, where only the XOR and ones-count relations are checked.

// File: rtl/rpq_pkg.sv
`timescale 1ns/1ps
package rpq_pkg;

   // summing structure used for the ones count
   typedef enum logic [0:0] {
      RPQ_SUM_CHAIN = 1'b0,
      RPQ_SUM_TREE  = 1'b1
   } rpq_sum_e;

   // width needed to hold a count from 0 to n inclusive
   function automatic int rpq_count_w(input int n);
      return $clog2(n + 1);
   endfunction

endpackage

// File: rtl/rpq_sampler.sv
`timescale 1ns/1ps
module rpq_sampler #(
   parameter int N_STAGES = 31
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [N_STAGES-1:0] taps_in,
   output logic [N_STAGES-1:0] smp_new,
   output logic [N_STAGES-1:0] smp_old,
   output logic                pair_ok
);

   localparam int FILL_W    = 2;
   localparam int FILL_FULL = 2;

   logic [FILL_W-1:0] fill_q;

   // two-deep phase history
   always_ff @(posedge clk) begin
      if (rst) begin
         smp_new <= '0;
         smp_old <= '0;
      end else begin
         smp_new <= taps_in;
         smp_old <= smp_new;
      end
   end

   // saturating count of samples stored since reset
   always_ff @(posedge clk) begin
      if (rst) begin
         fill_q <= '0;
      end else if (fill_q != FILL_W'(FILL_FULL)) begin
         fill_q <= fill_q + FILL_W'(1);
      end
   end

   assign pair_ok = (fill_q == FILL_W'(FILL_FULL));

endmodule

// File: rtl/rpq_popcount.sv
`timescale 1ns/1ps
module rpq_popcount #(
   parameter int                N_STAGES  = 31,
   parameter rpq_pkg::rpq_sum_e SUM_STYLE = rpq_pkg::RPQ_SUM_TREE,
   localparam int               COUNT_W   = rpq_pkg::rpq_count_w(N_STAGES)
) (
   input  logic [N_STAGES-1:0] vec_in,
   output logic [COUNT_W-1:0]  count_out
);

   if (SUM_STYLE == rpq_pkg::RPQ_SUM_CHAIN) begin : g_chain
      // serial accumulation, one adder per stage
      always_comb begin
         count_out = '0;
         for (int i = 0; i < N_STAGES; i++) begin
            count_out = count_out + COUNT_W'(vec_in[i]);
         end
      end
   end else begin : g_tree
      // partial sums over groups of four, then a short accumulation
      localparam int GRP    = 4;
      localparam int NGRP   = (N_STAGES + GRP - 1) / GRP;
      localparam int PADW   = NGRP * GRP;
      localparam int PART_W = $clog2(GRP + 1);

      logic [PADW-1:0]   padded;
      logic [PART_W-1:0] part [NGRP];

      always_comb begin
         padded                = '0;
         padded[N_STAGES-1:0]  = vec_in;
      end

      for (genvar g = 0; g < NGRP; g++) begin : g_grp
         assign part[g] = PART_W'(padded[g*GRP])
                        + PART_W'(padded[g*GRP+1])
                        + PART_W'(padded[g*GRP+2])
                        + PART_W'(padded[g*GRP+3]);
      end

      always_comb begin
         count_out = '0;
         for (int g = 0; g < NGRP; g++) begin
            count_out = count_out + COUNT_W'(part[g]);
         end
      end
   end

endmodule

// File: rtl/rpq_out_stage.sv
`timescale 1ns/1ps
module rpq_out_stage #(
   parameter int  N_STAGES = 31,
   localparam int COUNT_W  = rpq_pkg::rpq_count_w(N_STAGES)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                pair_ok,
   input  logic [N_STAGES-1:0] vec_in,
   input  logic [COUNT_W-1:0]  count_in,
   output logic                out_valid,
   output logic [COUNT_W-1:0]  out_count,
   output logic [N_STAGES-1:0] dac_enable
);

   // count and enable vector leave the block on the same edge
   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid  <= 1'b0;
         out_count  <= '0;
         dac_enable <= '0;
      end else if (pair_ok) begin
         out_valid  <= 1'b1;
         out_count  <= count_in;
         dac_enable <= vec_in;
      end
   end

endmodule

// File: rtl/ring_phase_quantizer.sv
`timescale 1ns/1ps
module ring_phase_quantizer #(
   parameter int                N_STAGES  = 31,
   parameter rpq_pkg::rpq_sum_e SUM_STYLE = rpq_pkg::RPQ_SUM_TREE,
   localparam int               COUNT_W   = rpq_pkg::rpq_count_w(N_STAGES)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [N_STAGES-1:0] phase_taps,
   output logic                out_valid,
   output logic [COUNT_W-1:0]  out_count,
   output logic [N_STAGES-1:0] dac_enable
);

   // elaboration-time parameter checks
   if (N_STAGES < 3) begin : g_bad_stages
      $error("ring_phase_quantizer: N_STAGES must be at least 3");
   end
   if (COUNT_W < 2) begin : g_bad_width
      $error("ring_phase_quantizer: derived count width too small");
   end

   logic [N_STAGES-1:0] smp_new;
   logic [N_STAGES-1:0] smp_old;
   logic                pair_ok;
   logic [N_STAGES-1:0] toggled;
   logic [COUNT_W-1:0]  toggle_cnt;

   rpq_sampler #(
      .N_STAGES (N_STAGES)
   ) u_sampler (
      .clk     (clk),
      .rst     (rst),
      .taps_in (phase_taps),
      .smp_new (smp_new),
      .smp_old (smp_old),
      .pair_ok (pair_ok)
   );

   // one comparator per delay stage
   for (genvar s = 0; s < N_STAGES; s++) begin : g_stage_cmp
      assign toggled[s] = smp_new[s] ^ smp_old[s];
   end

   rpq_popcount #(
      .N_STAGES  (N_STAGES),
      .SUM_STYLE (SUM_STYLE)
   ) u_popcount (
      .vec_in    (toggled),
      .count_out (toggle_cnt)
   );

   rpq_out_stage #(
      .N_STAGES (N_STAGES)
   ) u_out_stage (
      .clk        (clk),
      .rst        (rst),
      .pair_ok    (pair_ok),
      .vec_in     (toggled),
      .count_in   (toggle_cnt),
      .out_valid  (out_valid),
      .out_count  (out_count),
      .dac_enable (dac_enable)
   );

endmodule

// File: rtl/rpq_chk.sv
`timescale 1ns/1ps
module rpq_chk #(
   parameter int  N_STAGES = 31,
   localparam int COUNT_W  = rpq_pkg::rpq_count_w(N_STAGES)
) (
   input logic                clk,
   input logic                rst,
   input logic [N_STAGES-1:0] phase_taps,
   input logic                out_valid,
   input logic [COUNT_W-1:0]  out_count,
   input logic [N_STAGES-1:0] dac_enable
);

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (!out_valid && out_count == '0 && dac_enable == '0)); // R5

   AST_VEC_IS_XOR: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> dac_enable == ($past(phase_taps, 2) ^ $past(phase_taps, 3))); // R2

   AST_COUNT_WEIGHT: assert property (@(posedge clk) disable iff (rst)
      out_count == COUNT_W'($countones(dac_enable))); // R3

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      out_count <= COUNT_W'(N_STAGES)); // R3

   AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> out_valid); // R6

   AST_VALID_LATE: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !out_valid); // R6

endmodule

bind ring_phase_quantizer rpq_chk #(
   .N_STAGES (N_STAGES)
) u_rpq_chk (
   .clk        (clk),
   .rst        (rst),
   .phase_taps (phase_taps),
   .out_valid  (out_valid),
   .out_count  (out_count),
   .dac_enable (dac_enable)
);

// File: tb/ring_phase_quantizer_bench.sv
`timescale 1ns/1ps
module ring_phase_quantizer_bench;

   localparam int N   = 31;
   localparam int CW  = 5;
   localparam int N9  = 9;
   localparam int CW9 = 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [N-1:0]  taps = '0;
   logic [N9-1:0] taps9 = '0;
   logic          vld, vld9;
   logic [CW-1:0] cnt;
   logic [CW9-1:0] cnt9;
   logic [N-1:0]  dac;
   logic [N9-1:0] dac9;

   int checks = 0;
   int errors = 0;
   int pos    = 0;
   bit first_run = 1'b1;

   logic [N-1:0]  h  [$];
   logic [N9-1:0] h9 [$];
   int            adv_q [$];

   always #2.5 clk = ~clk;

   ring_phase_quantizer #(
      .N_STAGES  (N),
      .SUM_STYLE (rpq_pkg::RPQ_SUM_TREE)
   ) u_ring_phase_quantizer (
      .clk (clk), .rst (rst), .phase_taps (taps),
      .out_valid (vld), .out_count (cnt), .dac_enable (dac)
   );

   ring_phase_quantizer #(
      .N_STAGES  (N9),
      .SUM_STYLE (rpq_pkg::RPQ_SUM_CHAIN)
   ) u_ring_phase_quantizer_n9 (
      .clk (clk), .rst (rst), .phase_taps (taps9),
      .out_valid (vld9), .out_count (cnt9), .dac_enable (dac9)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // ideal ring: a thermometer front on a 2N phase circle
   function automatic logic [N-1:0] ring(input int p);
      logic [N-1:0] r;
      for (int i = 0; i < N; i++) begin
         r[i] = ((((p - i) % (2*N)) + 2*N) % (2*N)) < N;
      end
      return r;
   endfunction

   task automatic check_all();
      int k = h.size();
      if (k >= 3) begin
         logic [N-1:0]  ev  = h[k-2] ^ h[k-3];
         logic [N9-1:0] ev9 = h9[k-2] ^ h9[k-3];
         chk("R6 valid high", 64'(vld), 64'd1);
         chk("R1/R2/R4 vector", 64'(dac), 64'(ev));
         chk("R3 count", 64'(cnt), 64'($countones(ev)));
         chk(ev == '0 ? "R9 still taps" : "R7 advance", 64'(cnt), 64'(adv_q[k-2]));
         chk("R2 vector n9", 64'(dac9), 64'(ev9));
         chk("R3 count n9", 64'(cnt9), 64'($countones(ev9)));
         if (first_run && k == 3) begin
            chk("R8 vec a", 64'(dac9), 64'(9'b111100000));
            chk("R8 cnt a", 64'(cnt9), 64'd4);
         end
         if (first_run && k == 4) begin
            chk("R8 vec b", 64'(dac9), 64'(9'b100011111));
            chk("R8 cnt b", 64'(cnt9), 64'd6);
         end
         if (first_run && k == 5) begin
            chk("R8 vec c", 64'(dac9), 64'(9'b011111000));
            chk("R8 cnt c", 64'(cnt9), 64'd5);
         end
      end else begin
         chk("R6 valid low", 64'(vld), 64'd0);
         chk("R6 count held zero", 64'(cnt), 64'd0);
         chk("R6 vector held zero", 64'(dac), 64'd0);
         chk("R6 valid low n9", 64'(vld9), 64'd0);
      end
   endtask

   task automatic step(input int adv, input logic [N9-1:0] t9);
      pos   = (pos + adv) % (2*N);
      taps  = ring(pos);
      taps9 = t9;
      @(posedge clk);
      h.push_back(taps);
      h9.push_back(taps9);
      adv_q.push_back(adv);
      @(negedge clk);
      check_all();
   endtask

   task automatic do_reset(input int cycles);
      rst = 1'b1;
      for (int c = 0; c < cycles; c++) begin
         @(posedge clk);
         @(negedge clk);
         chk("R5 valid cleared", 64'(vld), 64'd0);
         chk("R5 count cleared", 64'(cnt), 64'd0);
         chk("R5 vector cleared", 64'(dac), 64'd0);
         chk("R5 n9 cleared", 64'({vld9, cnt9, dac9}), 64'd0);
      end
      rst = 1'b0;
      h.delete();
      h9.delete();
      adv_q.delete();
   endtask

   // watchdog
   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset(3);
      // stated 9-stage sequence, ring starts at phase 0
      step(0, 9'b101010101);
      step(3, 9'b010110101);
      step(0, 9'b110101010);
      step(1, 9'b101010010);
      first_run = 1'b0;
      // full toggle, stalls, wrap-around advances
      step(31, 9'h1F0);
      step(0,  9'h1F0);
      step(0,  9'h1F0);
      step(7,  9'h00F);
      step(15, 9'h0A5);
      step(30, 9'h15A);
      step(31, 9'h1FF);
      step(2,  9'h000);
      for (int i = 0; i < 40; i++) begin
         step((i * 11 + 3) % (N + 1), 9'((i * 37 + 5) % 512));
      end
      // reset in the middle of traffic
      do_reset(1);
      for (int i = 0; i < 30; i++) begin
         step((i * 7 + 1) % (N + 1), 9'((i * 91 + 17) % 512));
      end
      step(N, 9'h0);
      step(N, 9'h1FF);
      step(0, 9'h1FF);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule